// File: doc/BRIEF.md
# Jump-Folding Next-PC Buffer

This block sits in the fetch stage and takes unconditional direct jumps out of the instruction stream. Each entry is keyed by the address of the instruction that sits just before such a jump, and it holds the jump's target. When the current fetch address matches an entry, the block steers the next fetch address to the stored target instead of the sequential address. The jump instruction itself is therefore never fetched and costs no cycles.

Decode fills the buffer. When it recognises a jump, it presents the word address of the instruction before it, the decoded target word and a jump-kind code. Only unconditional direct jumps are stored. A jump is also skipped when the instruction before it was itself redirected. If that predecessor address is already held, its entry is rewritten in place. Otherwise the entry under a round-robin pointer is replaced. A synchronous flush empties the buffer.

Top module: `fold_tgt_buf`

## Requirements
- R1: After reset, every fetch address misses: `npc_sel` is 0 and `npc_value` equals `fetch_pc + 4`.
- R2: When `fetch_pc[31:2]` equals the stored predecessor word of a valid entry, `npc_sel` is 1 and `npc_value` is `{stored target word, 2'b00}`, in the same cycle.
- R3: When no valid entry matches, `npc_sel` is 0 and `npc_value` is `fetch_pc + 4`.
- R4: `fetch_pc[1:0]` takes no part in the match. All four byte offsets of a stored word hit, and a redirected `npc_value` always has bits [1:0] equal to 0.
- R5: An install with `ins_kind` = 2'b10 (conditional branch) changes no entry.
- R6: An install with `ins_kind` = 2'b11 (register-indirect jump) or 2'b00 (not a jump) changes no entry. Only 2'b01 (unconditional direct) is stored.
- R7: An install with `ins_pred_redir` = 1 changes no entry.
- R8: A lookup made in the same cycle as an install uses the contents from before that install. From the next cycle, the installed target is returned. Re-installing a predecessor word that is already held overwrites that entry and does not move the replacement pointer, so no word is ever held twice.
- R9: Installs of new predecessor words fill the entries in round-robin order starting at entry 0. With `ENTRIES` = 8, the ninth distinct install evicts the first one.
- R10: `flush` = 1 clears every entry at the next clock edge and returns the replacement pointer to entry 0. An install presented in the same cycle as a flush is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_pc | input | PC_W | Current fetch address |
| ins_valid | input | 1 | Decode presents a jump for installation |
| ins_kind | input | 2 | Jump kind: 00 none, 01 direct unconditional, 10 conditional, 11 register-indirect |
| ins_pred_redir | input | 1 | The instruction before the jump was itself redirected |
| ins_pred_word | input | PC_W-2 | Word address of the instruction before the jump |
| ins_tgt_word | input | PC_W-2 | Word address of the jump target |
| flush | input | 1 | Clear all entries |
| npc_sel | output | 1 | 1 when the next PC comes from the buffer |
| npc_value | output | PC_W | Next fetch address |

## Verification
The assertions check the following on every clock cycle:
- No two entries ever match the same word.
- A flush leaves the buffer empty.
- Rejected install kinds and installs after a redirected predecessor leave the stored state untouched.
- A redirected address is always word aligned.

Some behaviours can only be shown by the bench's scenarios, which sweep fetch addresses byte by byte against an arithmetic model:
- The one-cycle install latency, including a lookup of the old contents in the same cycle.
- The order of round-robin eviction.
- Update in place of a word that is already held.
- An install dropped when it coincides with a flush.

// File: rtl/fold_pkg.sv
package fold_pkg;
    typedef enum logic [1:0] {
        JK_NONE     = 2'b00,
        JK_DIRECT   = 2'b01,
        JK_COND     = 2'b10,
        JK_INDIRECT = 2'b11
    } jump_kind_e;
endpackage

// File: rtl/fold_match.sv
module fold_match #(
    parameter int N = 8,
    parameter int W = 30
) (
    input  logic [N-1:0]        vld,
    input  logic [N-1:0][W-1:0] tags,
    input  logic [W-1:0]        key,
    output logic [N-1:0]        hit
);
    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign hit[i] = vld[i] && (tags[i] == key);
    end
endmodule

// File: rtl/fold_pick.sv
module fold_pick #(
    parameter int N = 8,
    parameter int W = 30
) (
    input  logic [N-1:0]        sel,
    input  logic [N-1:0][W-1:0] data,
    output logic [W-1:0]        out
);
    always_comb begin
        out = '0;
        for (int i = 0; i < N; i++) begin
            if (sel[i]) out = out | data[i];
        end
    end
endmodule

// File: rtl/fold_rr.sv
module fold_rr #(
    parameter int N = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          adv,
    output logic [IW-1:0] ptr
);
    logic [IW-1:0] ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (clr) begin
            ptr_d = '0;
        end else if (adv) begin
            ptr_d = (ptr_q == IW'(N - 1)) ? '0 : ptr_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign ptr = ptr_q;

    AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q <= IW'(N - 1)) else $error("pointer out of range"); // R9
endmodule

// File: rtl/fold_tgt_buf.sv
module fold_tgt_buf
    import fold_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int PC_W    = 32,
    localparam int WW     = PC_W - 2,
    localparam int IW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] fetch_pc,
    input  logic            ins_valid,
    input  logic [1:0]      ins_kind,
    input  logic            ins_pred_redir,
    input  logic [WW-1:0]   ins_pred_word,
    input  logic [WW-1:0]   ins_tgt_word,
    input  logic            flush,
    output logic            npc_sel,
    output logic [PC_W-1:0] npc_value
);
    typedef struct packed {
        logic [ENTRIES-1:0]         vld;
        logic [ENTRIES-1:0][WW-1:0] tag;
        logic [ENTRIES-1:0][WW-1:0] tgt;
    } buf_state_t;

    buf_state_t st_d, st_q;

    logic [ENTRIES-1:0] fetch_hit, ins_hit;
    logic [WW-1:0]      hit_tgt;
    logic [IW-1:0]      rr_ptr;
    logic [IW-1:0]      upd_idx;
    logic               ins_ok, ins_known, alloc_new;
    jump_kind_e         kind;

    assign kind = jump_kind_e'(ins_kind);

    fold_match #(.N(ENTRIES), .W(WW)) u_fetch_match (
        .vld(st_q.vld), .tags(st_q.tag), .key(fetch_pc[PC_W-1:2]), .hit(fetch_hit)
    );

    fold_match #(.N(ENTRIES), .W(WW)) u_ins_match (
        .vld(st_q.vld), .tags(st_q.tag), .key(ins_pred_word), .hit(ins_hit)
    );

    fold_pick #(.N(ENTRIES), .W(WW)) u_pick (
        .sel(fetch_hit), .data(st_q.tgt), .out(hit_tgt)
    );

    assign ins_ok    = ins_valid && (kind == JK_DIRECT) && !ins_pred_redir && !flush;
    assign ins_known = |ins_hit;
    assign alloc_new = ins_ok && !ins_known;

    fold_rr #(.N(ENTRIES)) u_rr (
        .clk(clk), .rst_n(rst_n), .clr(flush), .adv(alloc_new), .ptr(rr_ptr)
    );

    always_comb begin
        upd_idx = rr_ptr;
        for (int i = 0; i < ENTRIES; i++) begin
            if (ins_hit[i]) upd_idx = IW'(i);
        end
    end

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d.vld = '0;
        end else if (ins_ok) begin
            st_d.vld[upd_idx] = 1'b1;
            st_d.tag[upd_idx] = ins_pred_word;
            st_d.tgt[upd_idx] = ins_tgt_word;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign npc_sel   = |fetch_hit;
    assign npc_value = npc_sel ? {hit_tgt, 2'b00} : fetch_pc + PC_W'(4);

    AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fetch_hit)) else $error("duplicate tag"); // R8
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (st_q.vld == '0)) else $error("flush left entries"); // R10
    AST_COND_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && kind == JK_COND && !flush) |=> $stable(st_q)) else $error("cond installed"); // R5
    AST_OTHER_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && (kind == JK_INDIRECT || kind == JK_NONE) && !flush) |=> $stable(st_q))
        else $error("indirect installed"); // R6
    AST_REDIR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && ins_pred_redir && !flush) |=> $stable(st_q)) else $error("redirected pred installed"); // R7
    AST_ALIGNED_TGT: assert property (@(posedge clk) disable iff (!rst_n)
        npc_sel |-> (npc_value[1:0] == 2'b00)) else $error("unaligned target"); // R4
endmodule

// File: tb/fold_tgt_buf_bench.sv
module fold_tgt_buf_bench;
    localparam int N  = 8;
    localparam int PW = 32;
    localparam int WW = PW - 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [PW-1:0] fetch_pc = '0;
    logic          ins_valid = 1'b0;
    logic [1:0]    ins_kind = 2'b00;
    logic          ins_pred_redir = 1'b0;
    logic [WW-1:0] ins_pred_word = '0;
    logic [WW-1:0] ins_tgt_word = '0;
    logic          flush = 1'b0;
    logic          npc_sel;
    logic [PW-1:0] npc_value;

    int vectors = 0;
    int errors  = 0;

    bit            m_vld [N];
    logic [WW-1:0] m_tag [N];
    logic [WW-1:0] m_tgt [N];
    int            m_ptr = 0;

    always #4 clk = ~clk;

    fold_tgt_buf #(.ENTRIES(N), .PC_W(PW)) u_fold_tgt_buf (
        .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .ins_valid(ins_valid),
        .ins_kind(ins_kind), .ins_pred_redir(ins_pred_redir),
        .ins_pred_word(ins_pred_word), .ins_tgt_word(ins_tgt_word),
        .flush(flush), .npc_sel(npc_sel), .npc_value(npc_value)
    );

    task automatic model_update(input bit v, input logic [1:0] k, input bit rd,
                                input logic [WW-1:0] pw, input logic [WW-1:0] tw, input bit fl);
        int idx;
        if (fl) begin
            for (int i = 0; i < N; i++) m_vld[i] = 1'b0;
            m_ptr = 0;
        end else if (v && k == 2'b01 && !rd) begin
            idx = -1;
            for (int i = 0; i < N; i++) if (m_vld[i] && m_tag[i] == pw) idx = i;
            if (idx < 0) begin
                idx = m_ptr;
                m_ptr = (m_ptr + 1) % N;
            end
            m_vld[idx] = 1'b1;
            m_tag[idx] = pw;
            m_tgt[idx] = tw;
        end
    endtask

    task automatic step(input string req, input logic [PW-1:0] pc,
                        input bit v, input logic [1:0] k, input bit rd,
                        input logic [PW-1:0] pred, input logic [PW-1:0] tgt, input bit fl);
        bit            exp_sel;
        logic [PW-1:0] exp_val;
        @(negedge clk);
        fetch_pc = pc; ins_valid = v; ins_kind = k; ins_pred_redir = rd;
        ins_pred_word = pred[PW-1:2]; ins_tgt_word = tgt[PW-1:2]; flush = fl;
        #1;
        exp_sel = 1'b0;
        exp_val = pc + 32'd4;
        for (int i = 0; i < N; i++) begin
            if (m_vld[i] && m_tag[i] == pc[PW-1:2]) begin
                exp_sel = 1'b1;
                exp_val = {m_tgt[i], 2'b00};
            end
        end
        vectors++;
        if (npc_sel !== exp_sel || npc_value !== exp_val) begin
            errors++;
            $display("FAIL %s pc=%h sel=%b exp %b value=%h exp %h",
                     req, pc, npc_sel, exp_sel, npc_value, exp_val);
        end
        model_update(v, k, rd, pred[PW-1:2], tgt[PW-1:2], fl);
    endtask

    task automatic look(input string req, input logic [PW-1:0] pc);
        step(req, pc, 1'b0, 2'b00, 1'b0, '0, '0, 1'b0);
    endtask

    task automatic sweep(input string req, input logic [PW-1:0] lo, input logic [PW-1:0] hi);
        for (logic [PW-1:0] a = lo; a <= hi; a++) look(req, a);
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) begin m_vld[i] = 1'b0; m_tag[i] = '0; m_tgt[i] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: empty after reset, across a byte sweep
        sweep("R1", 32'h0000_00F0, 32'h0000_0130);

        // R2 / R3 / R4: install and look up every byte offset
        step("R2", 32'h0, 1'b1, 2'b01, 1'b0, 32'h0000_0100, 32'h0000_2003, 1'b0);
        look("R2", 32'h0000_0100);
        look("R4", 32'h0000_0101);
        look("R4", 32'h0000_0102);
        look("R4", 32'h0000_0103);
        look("R3", 32'h0000_0104);
        look("R3", 32'h0000_00FC);

        // R8: same-cycle lookup sees old contents, then in-place update
        step("R8", 32'h0000_0200, 1'b1, 2'b01, 1'b0, 32'h0000_0200, 32'h0000_3000, 1'b0);
        look("R8", 32'h0000_0200);
        step("R8", 32'h0000_0200, 1'b1, 2'b01, 1'b0, 32'h0000_0200, 32'h0000_3400, 1'b0);
        look("R8", 32'h0000_0200);

        // R5 / R6 / R7: rejected installs
        step("R5", 32'h0, 1'b1, 2'b10, 1'b0, 32'h0000_0300, 32'h0000_4000, 1'b0);
        look("R5", 32'h0000_0300);
        step("R6", 32'h0, 1'b1, 2'b11, 1'b0, 32'h0000_0304, 32'h0000_4100, 1'b0);
        look("R6", 32'h0000_0304);
        step("R6", 32'h0, 1'b1, 2'b00, 1'b0, 32'h0000_0308, 32'h0000_4200, 1'b0);
        look("R6", 32'h0000_0308);
        step("R7", 32'h0, 1'b1, 2'b01, 1'b1, 32'h0000_030C, 32'h0000_4300, 1'b0);
        look("R7", 32'h0000_030C);
        sweep("R2", 32'h0000_00F8, 32'h0000_0310);

        // R10: flush beats an install in the same cycle
        step("R10", 32'h0000_0100, 1'b1, 2'b01, 1'b0, 32'h0000_5000, 32'h0000_6000, 1'b1);
        look("R10", 32'h0000_5000);
        look("R10", 32'h0000_0100);
        sweep("R10", 32'h0000_01F8, 32'h0000_0208);

        // R9: nine distinct installs from a clean pointer; the first is evicted
        for (int i = 0; i < N + 1; i++)
            step("R9", 32'h0, 1'b1, 2'b01, 1'b0, 32'h0000_1000 + 32'(i * 8),
                 32'h0000_8000 + 32'(i * 16), 1'b0);
        look("R9", 32'h0000_1000);
        look("R9", 32'h0000_1040);
        sweep("R9", 32'h0000_0FF0, 32'h0000_1050);

        // R8: update in place does not advance the pointer; next new install evicts 0x1008
        step("R8", 32'h0, 1'b1, 2'b01, 1'b0, 32'h0000_1010, 32'h0000_9000, 1'b0);
        step("R9", 32'h0, 1'b1, 2'b01, 1'b0, 32'h0000_2000, 32'h0000_A000, 1'b0);
        look("R9", 32'h0000_1008);
        look("R9", 32'h0000_1010);
        sweep("R9", 32'h0000_0FF8, 32'h0000_1048);
        sweep("R9", 32'h0000_1FFC, 32'h0000_2004);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule